// File: doc/BRIEF.md
# Data Space Decoder with Core Registers

This block sits between the load/store unit of a small 8-bit microcontroller core and the places a data byte can live. Each single-byte access on the unified data address space goes to one of three regions. The lowest addresses reach the general register file. The next window reaches the I/O ports. Everything above that reaches data memory. The block raises one read or write strobe toward the chosen region and passes on the index, port or address that the region needs.

The eight highest I/O ports are not sent to the I/O bus. Instead the block holds them itself as core special registers:
- four page-extension registers (D, X, Y and Z) that supply address bits 23:16;
- an indirect-jump extension register;
- a 16-bit stack pointer, reached as a low byte and a high byte;
- the status byte.

Parameters set which page registers exist and whether the stack pointer has a high byte. A write to a register that is not configured is dropped without any sign. Every read returns one cycle after it is issued, whichever region served it.

Top module: `dspace_decoder`

## Requirements
- R1: An address below 32 raises the register-file strobe (rf_re on a read, rf_we on a write), with rf_addr equal to the address. No other strobe is raised.
- R2: An address from 32 to 87 raises the I/O bus strobe, with io_port equal to the address minus 32. These are ports 0x00 to 0x37.
- R3: An address of 96 or more raises the memory strobe, with mem_addr equal to the full address.
- R4: An access to ports 0x38 to 0x3F (addresses 88 to 95) raises no strobe on any bus. It is served from the local core registers.
- R5: The page registers sit at port 0x38 (D), 0x39 (X), 0x3A (Y) and 0x3B (Z). A write stores the byte in bits 23:16 and clears bits 15:0. A read returns bits 23:16.
- R6: A write to a page register is dropped when that register's feature bit is clear. The feature bits are FEAT_PAGE bit 0 for D, bit 1 for X, bit 2 for Y and bit 3 for Z.
- R7: The jump-extension register at port 0x3C is always writable. It stores the byte in bits 23:16, and a read returns bits 23:16.
- R8: A write to port 0x3D replaces stack pointer bits 7:0 and keeps bits 15:8. A read returns bits 7:0.
- R9: A write to port 0x3E replaces stack pointer bits 15:8 only when TWO_BYTE_SP is 1. Otherwise it is dropped. A read returns bits 15:8.
- R10: Port 0x3F holds the status byte. A write stores it and a read returns it.
- R11: Only bits 7:0 of acc_wdata are used. Bits 15:8 reach no output and no register.
- R12: A read raises rd_valid in the next cycle, with rd_data taken from the selected source (rf_rdata, io_rdata or mem_rdata in that cycle, or the local register byte at the request). rd_valid is low in the cycle after a write or an idle cycle.
- R13: After reset all local registers read as zero and rd_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_addr | input | ADDR_W | Data-space byte address |
| acc_wdata | input | WIN_W | Store data (low byte used) |
| rd_valid | output | 1 | Load result valid |
| rd_data | output | 8 | Load result |
| rf_we | output | 1 | Register-file write strobe |
| rf_re | output | 1 | Register-file read strobe |
| rf_addr | output | log2(RF_COUNT) | Register index |
| rf_wdata | output | 8 | Register write byte |
| rf_rdata | input | 8 | Register read byte, one cycle after rf_re |
| io_we | output | 1 | I/O bus write strobe |
| io_re | output | 1 | I/O bus read strobe |
| io_port | output | log2(IO_COUNT) | I/O port number |
| io_wdata | output | 8 | I/O write byte |
| io_rdata | input | 8 | I/O read byte, one cycle after io_re |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, one cycle after mem_re |
| page_d | output | 24 | D page-extension value |
| page_x | output | 24 | X page-extension value |
| page_y | output | 24 | Y page-extension value |
| page_z | output | 24 | Z page-extension value |
| jump_ext | output | 24 | Indirect-jump extension value |
| stack_ptr | output | 16 | Stack pointer |
| status | output | 8 | Status byte |

## Verification
The assertions assume three things about the inputs. acc_write and acc_addr are meaningful only while acc_valid is high. Each region returns its read byte exactly one cycle after its strobe. The core does not update the stack pointer or status byte through any path other than this port. The stimulus issues one access followed by one idle cycle, and keeps the three read-data inputs at fixed, distinct bytes, so the source of every load can be identified. Random addresses are drawn in equal parts from the register range, the forwarded I/O ports, the eight local ports and memory. Random store data always has nonzero high bits. A second instance, with no page features and a one-byte stack pointer, receives the same stimulus to exercise the dropped writes.

// File: rtl/dsd_pkg.sv
package dsd_pkg;

    localparam int N_SPECIAL = 8;
    localparam int N_PAGE    = 4;
    localparam int PAGE_W    = 24;
    localparam int SP_W      = 16;

    // Local register index = port - (IO_COUNT - N_SPECIAL); order fixed by port map
    localparam logic [2:0] SIDX_PAGE_D = 3'd0;
    localparam logic [2:0] SIDX_PAGE_X = 3'd1;
    localparam logic [2:0] SIDX_PAGE_Y = 3'd2;
    localparam logic [2:0] SIDX_PAGE_Z = 3'd3;
    localparam logic [2:0] SIDX_JUMP   = 3'd4;
    localparam logic [2:0] SIDX_SP_LO  = 3'd5;
    localparam logic [2:0] SIDX_SP_HI  = 3'd6;
    localparam logic [2:0] SIDX_STATUS = 3'd7;

    typedef enum logic [1:0] {
        RGN_RF  = 2'd0,
        RGN_IO  = 2'd1,
        RGN_MEM = 2'd2
    } region_e;

    typedef enum logic [1:0] {
        SRC_RF  = 2'd0,
        SRC_IO  = 2'd1,
        SRC_MEM = 2'd2,
        SRC_SPC = 2'd3
    } rsrc_e;

    typedef struct packed {
        region_e    rgn;
        logic       special;
        logic [2:0] sidx;
    } decoded_t;

    function automatic logic [PAGE_W-1:0] to_page(input logic [7:0] b);
        return {b, 16'h0000};
    endfunction

    function automatic logic [7:0] from_page(input logic [PAGE_W-1:0] v);
        return v[PAGE_W-1:PAGE_W-8];
    endfunction

    function automatic rsrc_e source_of(input decoded_t d);
        if (d.special)            return SRC_SPC;
        else if (d.rgn == RGN_RF) return SRC_RF;
        else if (d.rgn == RGN_IO) return SRC_IO;
        else                      return SRC_MEM;
    endfunction

endpackage

// File: rtl/dsd_region_decode.sv
module dsd_region_decode
    import dsd_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int RF_COUNT = 32,
    parameter int IO_COUNT = 64
) (
    input  logic [ADDR_W-1:0]           addr,
    output decoded_t                    dec,
    output logic [$clog2(RF_COUNT)-1:0] rf_idx,
    output logic [$clog2(IO_COUNT)-1:0] io_port
);
    localparam int RF_IDX_W  = $clog2(RF_COUNT);
    localparam int IO_PORT_W = $clog2(IO_COUNT);
    localparam logic [ADDR_W-1:0]    RF_END   = ADDR_W'(RF_COUNT);
    localparam logic [ADDR_W-1:0]    IO_END   = ADDR_W'(RF_COUNT + IO_COUNT);
    localparam logic [IO_PORT_W-1:0] SPC_BASE = IO_PORT_W'(IO_COUNT - N_SPECIAL);

    logic [ADDR_W-1:0]    io_off;
    logic [IO_PORT_W-1:0] spc_off;
    logic                 unused_dec;

    always_comb begin
        io_off  = addr - RF_END;
        io_port = io_off[IO_PORT_W-1:0];
        rf_idx  = addr[RF_IDX_W-1:0];
        spc_off = io_port - SPC_BASE;
        if (addr < RF_END)      dec.rgn = RGN_RF;
        else if (addr < IO_END) dec.rgn = RGN_IO;
        else                    dec.rgn = RGN_MEM;
        dec.special = (dec.rgn == RGN_IO) && (io_port >= SPC_BASE);
        dec.sidx    = spc_off[2:0];
    end

    assign unused_dec = ^{io_off[ADDR_W-1:IO_PORT_W], spc_off[IO_PORT_W-1:3]};
endmodule

// File: rtl/dsd_core_regs.sv
module dsd_core_regs
    import dsd_pkg::*;
#(
    parameter logic [N_PAGE-1:0] FEAT_PAGE   = 4'b1110,
    parameter bit                TWO_BYTE_SP = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [2:0]                    wr_idx,
    input  logic [7:0]                    wbyte,
    input  logic [2:0]                    rd_idx,
    output logic [7:0]                    rd_byte,
    output logic [N_PAGE-1:0][PAGE_W-1:0] page_q,
    output logic [PAGE_W-1:0]             jump_q,
    output logic [SP_W-1:0]               sp_q,
    output logic [7:0]                    sreg_q
);
    for (genvar g = 0; g < N_PAGE; g++) begin : g_page
        if (FEAT_PAGE[g]) begin : g_on
            logic [PAGE_W-1:0] r;
            always_ff @(posedge clk) begin
                if (rst)                                    r <= '0;
                else if (wr_en && wr_idx == 3'(SIDX_PAGE_D + g)) r <= to_page(wbyte);
            end
            assign page_q[g] = r;

            // R5
            page_load_chk: assert property (@(posedge clk) disable iff (rst)
                (wr_en && wr_idx == 3'(SIDX_PAGE_D + g)) |=>
                (page_q[g] == {$past(wbyte), 16'h0000}));
        end else begin : g_off
            assign page_q[g] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            jump_q <= '0;
            sp_q   <= '0;
            sreg_q <= '0;
        end else if (wr_en) begin
            if (wr_idx == SIDX_JUMP)                  jump_q      <= to_page(wbyte);
            if (wr_idx == SIDX_SP_LO)                 sp_q[7:0]   <= wbyte;
            if (wr_idx == SIDX_SP_HI && TWO_BYTE_SP)  sp_q[15:8]  <= wbyte;
            if (wr_idx == SIDX_STATUS)                sreg_q      <= wbyte;
        end
    end

    always_comb begin
        case (rd_idx)
            SIDX_JUMP:   rd_byte = from_page(jump_q);
            SIDX_SP_LO:  rd_byte = sp_q[7:0];
            SIDX_SP_HI:  rd_byte = sp_q[15:8];
            SIDX_STATUS: rd_byte = sreg_q;
            default:     rd_byte = from_page(page_q[rd_idx[1:0]]);
        endcase
    end

    // R7
    jump_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == SIDX_JUMP) |=> (jump_q == {$past(wbyte), 16'h0000}));

    // R8
    sp_lo_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == SIDX_SP_LO) |=>
        (sp_q[7:0] == $past(wbyte) && sp_q[15:8] == $past(sp_q[15:8])));

    // R9
    sp_hi_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == SIDX_SP_HI) |=>
        (sp_q[15:8] == (TWO_BYTE_SP ? $past(wbyte) : $past(sp_q[15:8]))));
endmodule

// File: rtl/dsd_read_return.sv
module dsd_read_return
    import dsd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rd_req,
    input  rsrc_e      src,
    input  logic [7:0] spc_byte,
    input  logic [7:0] rf_rdata,
    input  logic [7:0] io_rdata,
    input  logic [7:0] mem_rdata,
    output logic       rd_valid,
    output logic [7:0] rd_data
);
    logic       valid_q;
    rsrc_e      src_q;
    logic [7:0] spc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            src_q   <= SRC_RF;
            spc_q   <= '0;
        end else begin
            valid_q <= rd_req;
            if (rd_req) begin
                src_q <= src;
                spc_q <= spc_byte;
            end
        end
    end

    always_comb begin
        rd_valid = valid_q;
        rd_data  = '0;
        if (valid_q) begin
            case (src_q)
                SRC_RF:  rd_data = rf_rdata;
                SRC_IO:  rd_data = io_rdata;
                SRC_MEM: rd_data = mem_rdata;
                default: rd_data = spc_q;
            endcase
        end
    end

    // R12
    rd_follow_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rd_valid);

    // R12
    rd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !rd_valid);
endmodule

// File: rtl/dspace_decoder.sv
module dspace_decoder
    import dsd_pkg::*;
#(
    parameter int                ADDR_W      = 24,
    parameter int                WIN_W       = 16,
    parameter int                RF_COUNT    = 32,
    parameter int                IO_COUNT    = 64,
    parameter logic [N_PAGE-1:0] FEAT_PAGE   = 4'b1110,
    parameter bit                TWO_BYTE_SP = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          acc_valid,
    input  logic                          acc_write,
    input  logic [ADDR_W-1:0]             acc_addr,
    input  logic [WIN_W-1:0]              acc_wdata,
    output logic                          rd_valid,
    output logic [7:0]                    rd_data,
    output logic                          rf_we,
    output logic                          rf_re,
    output logic [$clog2(RF_COUNT)-1:0]   rf_addr,
    output logic [7:0]                    rf_wdata,
    input  logic [7:0]                    rf_rdata,
    output logic                          io_we,
    output logic                          io_re,
    output logic [$clog2(IO_COUNT)-1:0]   io_port,
    output logic [7:0]                    io_wdata,
    input  logic [7:0]                    io_rdata,
    output logic                          mem_we,
    output logic                          mem_re,
    output logic [ADDR_W-1:0]             mem_addr,
    output logic [7:0]                    mem_wdata,
    input  logic [7:0]                    mem_rdata,
    output logic [PAGE_W-1:0]             page_d,
    output logic [PAGE_W-1:0]             page_x,
    output logic [PAGE_W-1:0]             page_y,
    output logic [PAGE_W-1:0]             page_z,
    output logic [PAGE_W-1:0]             jump_ext,
    output logic [SP_W-1:0]               stack_ptr,
    output logic [7:0]                    status
);
    localparam int IO_PORT_W = $clog2(IO_COUNT);
    localparam logic [IO_PORT_W-1:0] SPC_BASE = IO_PORT_W'(IO_COUNT - N_SPECIAL);

    decoded_t                    dec;
    logic [7:0]                  wbyte;
    logic [7:0]                  spc_byte;
    logic                        do_wr;
    logic                        do_rd;
    logic [N_PAGE-1:0][PAGE_W-1:0] page_q;
    logic                        unused_win;

    assign wbyte      = acc_wdata[7:0];
    assign unused_win = ^acc_wdata[WIN_W-1:8];
    assign do_wr      = acc_valid &&  acc_write;
    assign do_rd      = acc_valid && !acc_write;

    dsd_region_decode #(
        .ADDR_W   (ADDR_W),
        .RF_COUNT (RF_COUNT),
        .IO_COUNT (IO_COUNT)
    ) u_dec (
        .addr    (acc_addr),
        .dec     (dec),
        .rf_idx  (rf_addr),
        .io_port (io_port)
    );

    always_comb begin
        rf_we     = do_wr && dec.rgn == RGN_RF;
        rf_re     = do_rd && dec.rgn == RGN_RF;
        io_we     = do_wr && dec.rgn == RGN_IO && !dec.special;
        io_re     = do_rd && dec.rgn == RGN_IO && !dec.special;
        mem_we    = do_wr && dec.rgn == RGN_MEM;
        mem_re    = do_rd && dec.rgn == RGN_MEM;
        mem_addr  = acc_addr;
        rf_wdata  = wbyte;
        io_wdata  = wbyte;
        mem_wdata = wbyte;
    end

    dsd_core_regs #(
        .FEAT_PAGE   (FEAT_PAGE),
        .TWO_BYTE_SP (TWO_BYTE_SP)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (do_wr && dec.special),
        .wr_idx  (dec.sidx),
        .wbyte   (wbyte),
        .rd_idx  (dec.sidx),
        .rd_byte (spc_byte),
        .page_q  (page_q),
        .jump_q  (jump_ext),
        .sp_q    (stack_ptr),
        .sreg_q  (status)
    );

    assign page_d = page_q[0];
    assign page_x = page_q[1];
    assign page_y = page_q[2];
    assign page_z = page_q[3];

    dsd_read_return u_ret (
        .clk       (clk),
        .rst       (rst),
        .rd_req    (do_rd),
        .src       (source_of(dec)),
        .spc_byte  (spc_byte),
        .rf_rdata  (rf_rdata),
        .io_rdata  (io_rdata),
        .mem_rdata (mem_rdata),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    // R1
    one_target_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rf_we, rf_re, io_we, io_re, mem_we, mem_re}));

    // R4
    no_special_on_bus_chk: assert property (@(posedge clk) disable iff (rst)
        (io_we || io_re) |-> (io_port < SPC_BASE));
endmodule

// File: tb/tb_dspace_decoder.sv
module tb_dspace_decoder;
    localparam logic [3:0] FP_A  = 4'b1110;
    localparam bit         SPH_A = 1'b1;
    localparam logic [3:0] FP_B  = 4'b0000;
    localparam bit         SPH_B = 1'b0;
    localparam logic [7:0] RF_BYTE  = 8'hA1;
    localparam logic [7:0] IO_BYTE  = 8'hB2;
    localparam logic [7:0] MEM_BYTE = 8'hC3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic acc_valid = 1'b0, acc_write = 1'b0;
    logic [23:0] acc_addr = '0;
    logic [15:0] acc_wdata = '0;
    logic [7:0]  rf_rdata = RF_BYTE, io_rdata = IO_BYTE, mem_rdata = MEM_BYTE;

    logic [1:0] rd_valid;
    logic [1:0][7:0] rd_data, rf_wdata, io_wdata, mem_wdata, status;
    logic [1:0] rf_we, rf_re, io_we, io_re, mem_we, mem_re;
    logic [1:0][4:0] rf_addr;
    logic [1:0][5:0] io_port;
    logic [1:0][23:0] mem_addr, page_d, page_x, page_y, page_z, jump_ext;
    logic [1:0][15:0] stack_ptr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state per instance: [inst][local index 0..7]
    logic [7:0] mreg [2][8];

    always #5 clk = ~clk;

    dspace_decoder #(.FEAT_PAGE(FP_A), .TWO_BYTE_SP(SPH_A)) dut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .rd_valid(rd_valid[0]), .rd_data(rd_data[0]),
        .rf_we(rf_we[0]), .rf_re(rf_re[0]), .rf_addr(rf_addr[0]), .rf_wdata(rf_wdata[0]), .rf_rdata(rf_rdata),
        .io_we(io_we[0]), .io_re(io_re[0]), .io_port(io_port[0]), .io_wdata(io_wdata[0]), .io_rdata(io_rdata),
        .mem_we(mem_we[0]), .mem_re(mem_re[0]), .mem_addr(mem_addr[0]), .mem_wdata(mem_wdata[0]), .mem_rdata(mem_rdata),
        .page_d(page_d[0]), .page_x(page_x[0]), .page_y(page_y[0]), .page_z(page_z[0]),
        .jump_ext(jump_ext[0]), .stack_ptr(stack_ptr[0]), .status(status[0]));

    dspace_decoder #(.FEAT_PAGE(FP_B), .TWO_BYTE_SP(SPH_B)) dut_nf (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .rd_valid(rd_valid[1]), .rd_data(rd_data[1]),
        .rf_we(rf_we[1]), .rf_re(rf_re[1]), .rf_addr(rf_addr[1]), .rf_wdata(rf_wdata[1]), .rf_rdata(rf_rdata),
        .io_we(io_we[1]), .io_re(io_re[1]), .io_port(io_port[1]), .io_wdata(io_wdata[1]), .io_rdata(io_rdata),
        .mem_we(mem_we[1]), .mem_re(mem_re[1]), .mem_addr(mem_addr[1]), .mem_wdata(mem_wdata[1]), .mem_rdata(mem_rdata),
        .page_d(page_d[1]), .page_x(page_x[1]), .page_y(page_y[1]), .page_z(page_z[1]),
        .jump_ext(jump_ext[1]), .stack_ptr(stack_ptr[1]), .status(status[1]));

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit wr_allowed(input int inst, input int idx);
        logic [3:0] fp = (inst == 0) ? FP_A : FP_B;
        bit sph = (inst == 0) ? SPH_A : SPH_B;
        if (idx < 4)  return fp[idx];
        if (idx == 6) return sph;
        return 1'b1;
    endfunction

    task automatic check_regs(input string tag);
        for (int i = 0; i < 2; i++) begin
            chk(page_d[i] == {mreg[i][0], 16'h0}, {"R5/R6 page D ", tag}, page_d[i], {mreg[i][0], 16'h0});
            chk(page_x[i] == {mreg[i][1], 16'h0}, {"R5/R6 page X ", tag}, page_x[i], {mreg[i][1], 16'h0});
            chk(page_y[i] == {mreg[i][2], 16'h0}, {"R5/R6 page Y ", tag}, page_y[i], {mreg[i][2], 16'h0});
            chk(page_z[i] == {mreg[i][3], 16'h0}, {"R5/R6 page Z ", tag}, page_z[i], {mreg[i][3], 16'h0});
            chk(jump_ext[i] == {mreg[i][4], 16'h0}, {"R7 jump ", tag}, jump_ext[i], {mreg[i][4], 16'h0});
            chk(stack_ptr[i] == {mreg[i][6], mreg[i][5]}, {"R8/R9 sp ", tag}, stack_ptr[i], {mreg[i][6], mreg[i][5]});
            chk(status[i] == mreg[i][7], {"R10 status ", tag}, status[i], mreg[i][7]);
        end
    endtask

    task automatic do_op(input logic [23:0] a, input bit w, input logic [15:0] d);
        logic [7:0] b = d[7:0];
        bit is_rf  = a < 24'd32;
        bit is_io  = !is_rf && a < 24'd88;
        bit is_spc = a >= 24'd88 && a < 24'd96;
        bit is_mem = a >= 24'd96;
        int sidx = int'(a) - 88;
        logic [1:0][7:0] exp_rd;
        @(negedge clk);
        acc_valid = 1'b1; acc_write = w; acc_addr = a; acc_wdata = d;
        #1;
        for (int i = 0; i < 2; i++) begin
            // R1 R2 R3 R4: strobes
            chk(rf_we[i] == (is_rf && w) && rf_re[i] == (is_rf && !w), "R1 rf strobe", {rf_we[i], rf_re[i]}, {is_rf && w, is_rf && !w});
            chk(io_we[i] == (is_io && w) && io_re[i] == (is_io && !w), "R2/R4 io strobe", {io_we[i], io_re[i]}, {is_io && w, is_io && !w});
            chk(mem_we[i] == (is_mem && w) && mem_re[i] == (is_mem && !w), "R3 mem strobe", {mem_we[i], mem_re[i]}, {is_mem && w, is_mem && !w});
            if (is_rf)  chk(rf_addr[i] == a[4:0], "R1 rf_addr", rf_addr[i], a[4:0]);
            if (is_io)  chk(io_port[i] == 6'(a - 24'd32), "R2 io_port", io_port[i], 6'(a - 24'd32));
            if (is_mem) chk(mem_addr[i] == a, "R3 mem_addr", mem_addr[i], a);
            if (w && is_rf)  chk(rf_wdata[i] == b, "R11 rf_wdata", rf_wdata[i], b);
            if (w && is_io)  chk(io_wdata[i] == b, "R11 io_wdata", io_wdata[i], b);
            if (w && is_mem) chk(mem_wdata[i] == b, "R11 mem_wdata", mem_wdata[i], b);
            exp_rd[i] = is_rf ? RF_BYTE : is_io ? IO_BYTE : is_mem ? MEM_BYTE : mreg[i][sidx];
        end
        @(posedge clk);
        @(negedge clk);
        acc_valid = 1'b0;
        if (w && is_spc)
            for (int i = 0; i < 2; i++)
                if (wr_allowed(i, sidx)) mreg[i][sidx] = b;
        for (int i = 0; i < 2; i++) begin
            chk(rd_valid[i] == !w, "R12 rd_valid", rd_valid[i], !w);
            if (!w) chk(rd_data[i] == exp_rd[i], is_spc ? "R5-R10 local read" : "R12 rd_data", rd_data[i], exp_rd[i]);
        end
        check_regs(is_spc ? "after local access" : "after bus access");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [23:0] a;
        void'($urandom(32'd2024));
        for (int i = 0; i < 2; i++) for (int k = 0; k < 8; k++) mreg[i][k] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R13 reset state
        chk(rd_valid == 2'b00, "R13 rd_valid after reset", rd_valid, 0);
        check_regs("R13 reset");

        // directed boundaries R1 R2 R3 R4
        do_op(24'd0,  1'b0, 16'h0);
        do_op(24'd31, 1'b1, 16'hFF5A);
        do_op(24'd32, 1'b1, 16'h8011);
        do_op(24'd87, 1'b0, 16'h0);
        do_op(24'd96, 1'b0, 16'h0);
        do_op(24'hFFFFFF, 1'b1, 16'h7E3C);
        // every local port written with high bits set (R11), then read back
        for (int k = 0; k < 8; k++) do_op(24'd88 + 24'(k), 1'b1, {8'hE7, 8'h10 + 8'(k * 17)});
        for (int k = 0; k < 8; k++) do_op(24'd88 + 24'(k), 1'b0, 16'h0);
        // R8: low byte keeps high; R9 high byte gated
        do_op(24'd94, 1'b1, 16'h00C4);
        do_op(24'd93, 1'b1, 16'h0099);
        do_op(24'd93, 1'b0, 16'h0);
        do_op(24'd94, 1'b0, 16'h0);
        // R6: D page dropped on dut, all pages dropped on dut_nf
        do_op(24'd88, 1'b1, 16'h0055);
        do_op(24'd88, 1'b0, 16'h0);

        for (int n = 0; n < 600; n++) begin
            case ($urandom % 4)
                0:       a = 24'($urandom % 32);
                1:       a = 24'(32 + $urandom % 56);
                2:       a = 24'(88 + $urandom % 8);
                default: a = 24'(96 + $urandom % 32'hFFFF00);
            endcase
            do_op(a, 1'($urandom), {8'h01 | 8'($urandom), 8'($urandom)});
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule